// File: doc/BRIEF.md
# Indexed Codec Register Host Interface

This block is the host-facing register file of an audio codec controller. A byte-wide parallel bus uses a 2-bit address, a read strobe and a write strobe to reach four direct registers. These are an index pointer, an indexed data window, a status byte and a playback data byte. The indexed data window reads and writes one entry of a 32-entry indirect bank, and the index pointer selects which entry.

After reset the block spends a fixed number of cycles initialising. During that time it locks out host access to the pointer and the window. The index byte also holds two control flags:

- a mode-change flag, which mutes the DAC and opens the format and configuration entries to writes;
- a transfer-request-disable flag, which is stored only.

The block keeps an interrupt status bit, sets it from a request input and presents it on an IRQ output. The IRQ output is gated by an enable bit held in the indirect bank.

Top module: `codec_reg_host`

## Requirements
- R1: For `INIT_CYCLES` clock cycles after reset is released, reads of address 0 (index) and address 1 (indexed data) return 0x80. Writes to those two addresses in that period change nothing.
- R2: Once initialisation ends, the index register reads 0x40. Its layout is: bit 7 is the init flag (read-only), bit 6 is mode-change, bit 5 is transfer-request-disable, and bits 4..0 are the pointer.
- R3: In mode 1, index bits 3..0 select indirect entries 0..15 for reads and writes through address 1. Index bit 4 is not stored and reads as 0.
- R4: Indirect entry 12 bit 6 selects mode 2. In mode 2, index bit 4 is stored and reads back, and it extends the pointer to entries 16..31.
- R5: Status (address 2) returns the following, with bits 7..3 reading as zero:
  - bit 0: interrupt status;
  - bit 1: the `pbReady` input;
  - bit 2: the `pbLeft` input.
- R6: The interrupt status bit is set by `intSet`. It is cleared by any write of any value to address 2. If both happen in the same cycle, the bit stays set.
- R7: `irq` is high exactly when interrupt status is set and indirect entry 10 bit 1 is set.
- R8: `dacMute` is high while the mode-change flag is set. This includes the whole initialisation period.
- R9: The following entries are gated by the mode-change flag:
  - entries 8 and 28 accept writes only while the flag is set;
  - entry 9 bits 1..0 (the enable bits) accept writes at any time;
  - entry 9 bits 7..2 accept writes only while the flag is set.
- R10: A write to address 3 stores the playback data byte, and a read of address 3 returns it.
- R11: `rdData` is 0 whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Direct register select |
| wrEn | input | 1 | Write strobe, sampled at the clock edge |
| rdEn | input | 1 | Read strobe; enables `rdData` |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data |
| intSet | input | 1 | Interrupt request pulse |
| pbReady | input | 1 | Playback-ready flag shown in status |
| pbLeft | input | 1 | Playback left/right flag shown in status |
| irq | output | 1 | Gated interrupt output |
| dacMute | output | 1 | DAC mute, follows the mode-change flag |

## Verification
Reaching indirect entries 16..31 is the hardest case. It needs a write through the window to entry 12 to enter mode 2, and only then a pointer write with bit 4 set. The stimulus checks that bit 4 is dropped before mode 2 is entered and kept afterwards. It also checks that entries 3 and 19 hold different values. A clear and a set landing in the same cycle is the other hard case. The stimulus writes status in the same cycle that `intSet` pulses.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 5;
  localparam int BANK_N = 1 << PTR_W;

  localparam logic [ADDR_W-1:0] A_INDEX  = 2'd0;
  localparam logic [ADDR_W-1:0] A_WINDOW = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] A_PBDATA = 2'd3;

  localparam logic [DATA_W-1:0] LOCKED_READ = 8'h80;

  typedef struct packed {
    logic idxWr;
    logic winWr;
    logic statClr;
    logic pbWr;
    logic inInit;
  } busStrobes_t;
endpackage

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl
  import codec_reg_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output busStrobes_t       strb
);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES);

  logic [CNT_W-1:0] initCnt;
  logic             busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initCnt <= '0;
    else if (busy) initCnt <= initCnt + 1'b1;
  end

  assign busy = (initCnt != INIT_LAST);

  always_comb begin
    strb.inInit  = busy;
    strb.idxWr   = wrEn && !busy && (addr == A_INDEX);
    strb.winWr   = wrEn && !busy && (addr == A_WINDOW);
    strb.statClr = wrEn && (addr == A_STATUS);
    strb.pbWr    = wrEn && (addr == A_PBDATA);
  end

  AST_INIT_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy); // R1
endmodule

// File: rtl/codec_reg_dp.sv
module codec_reg_dp
  import codec_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intSet,
  input  logic              pbReady,
  input  logic              pbLeft,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              dacMute
);
  localparam int E_PLAYFMT = 8;
  localparam int E_IFCFG   = 9;
  localparam int E_PINCTL  = 10;
  localparam int E_MODE    = 12;
  localparam int E_CAPFMT  = 28;
  localparam int B_IRQEN   = 1;
  localparam int B_MODE2   = 6;
  localparam int ENABLE_W  = 2;

  logic [DATA_W-1:0] bank [BANK_N];
  logic [PTR_W-1:0]  idxPtr;
  logic              modeChg;
  logic              xferOff;
  logic              intStat;
  logic [DATA_W-1:0] pbByte;
  logic              mode2;
  logic [PTR_W-1:0]  effPtr;
  logic [DATA_W-1:0] winNext;
  logic [DATA_W-1:0] idxView;

  assign mode2  = bank[E_MODE][B_MODE2];
  assign effPtr = {idxPtr[PTR_W-1] & mode2, idxPtr[PTR_W-2:0]};

  always_comb begin
    winNext = wrData;
    if (effPtr == PTR_W'(E_PLAYFMT) || effPtr == PTR_W'(E_CAPFMT)) begin
      if (!modeChg) winNext = bank[effPtr];
    end else if (effPtr == PTR_W'(E_IFCFG)) begin
      if (!modeChg) winNext = {bank[effPtr][DATA_W-1:ENABLE_W], wrData[ENABLE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_N; i++) bank[i] <= '0;
    end else if (strb.winWr) begin
      bank[effPtr] <= winNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxPtr  <= '0;
      modeChg <= 1'b1;
      xferOff <= 1'b0;
    end else if (strb.idxWr) begin
      idxPtr  <= {wrData[PTR_W-1] & mode2, wrData[PTR_W-2:0]};
      modeChg <= wrData[6];
      xferOff <= wrData[5];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStat <= 1'b0;
    else if (intSet) intStat <= 1'b1;
    else if (strb.statClr) intStat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pbByte <= '0;
    else if (strb.pbWr) pbByte <= wrData;
  end

  assign idxView = {1'b0, modeChg, xferOff, effPtr};

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        A_INDEX:  rdData = strb.inInit ? LOCKED_READ : idxView;
        A_WINDOW: rdData = strb.inInit ? LOCKED_READ : bank[effPtr];
        A_STATUS: rdData = {5'b0, pbLeft, pbReady, intStat};
        default:  rdData = pbByte;
      endcase
    end
  end

  assign irq     = intStat & bank[E_PINCTL][B_IRQEN];
  assign dacMute = modeChg;

  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.statClr && !intSet |=> !intStat); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    intSet |=> intStat); // R6
  AST_PLAYFMT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strb.winWr && !modeChg && effPtr == PTR_W'(E_PLAYFMT) |=> $stable(bank[E_PLAYFMT])); // R9
  AST_IDX_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.inInit |=> $stable(idxPtr) && modeChg); // R1
endmodule

// File: rtl/codec_reg_host.sv
module codec_reg_host
  import codec_reg_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              intSet,
  input  logic              pbReady,
  input  logic              pbLeft,
  output logic              irq,
  output logic              dacMute
);
  busStrobes_t strb;

  codec_reg_ctrl #(.INIT_CYCLES(INIT_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .strb(strb)
  );

  codec_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .rdEn(rdEn),
    .wrData(wrData), .intSet(intSet), .pbReady(pbReady), .pbLeft(pbLeft),
    .rdData(rdData), .irq(irq), .dacMute(dacMute)
  );

  AST_INIT_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.inInit && rdEn && addr != A_STATUS && addr != A_PBDATA |-> rdData == LOCKED_READ); // R1
  AST_MUTE_IN_INIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.inInit |-> dacMute); // R8
endmodule

// File: tb/codec_reg_host_tb.sv
module codec_reg_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_N     = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       intSet = 1'b0;
  logic       pbReady = 1'b0;
  logic       pbLeft = 1'b0;
  logic       irq;
  logic       dacMute;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_reg_host #(.INIT_CYCLES(INIT_N)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .intSet(intSet), .pbReady(pbReady),
    .pbLeft(pbLeft), .irq(irq), .dacMute(dacMute)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic testInit();
    logic [7:0] v;
    busRead(2'd0, v); check("R1 index locked", v, 8'h80);
    busWrite(2'd0, 8'h0A);
    busWrite(2'd1, 8'h55);
    busRead(2'd1, v); check("R1 window locked", v, 8'h80);
    check("R8 mute in init", {7'b0, dacMute}, 8'h01);
    check("R7 irq low", {7'b0, irq}, 8'h00);
    repeat (INIT_N + 2) @(negedge clk);
    busRead(2'd0, v); check("R2 index after init", v, 8'h40);
    busRead(2'd1, v); check("R1 entry0 unchanged", v, 8'h00);
  endtask

  task automatic testMode1();
    logic [7:0] v;
    busWrite(2'd0, 8'h43);
    busWrite(2'd1, 8'hA5);
    busRead(2'd1, v); check("R3 entry3 readback", v, 8'hA5);
    busWrite(2'd0, 8'h53);
    busRead(2'd0, v); check("R3 bit4 dropped", v, 8'h43);
    busRead(2'd1, v); check("R3 still entry3", v, 8'hA5);
  endtask

  task automatic testMode2();
    logic [7:0] v;
    busWrite(2'd0, 8'h4C);
    busWrite(2'd1, 8'h40);
    busWrite(2'd0, 8'h53);
    busRead(2'd0, v); check("R4 bit4 kept", v, 8'h53);
    busWrite(2'd1, 8'h3C);
    busRead(2'd1, v); check("R4 entry19", v, 8'h3C);
    busWrite(2'd0, 8'h43);
    busRead(2'd1, v); check("R4 entry3 distinct", v, 8'hA5);
  endtask

  task automatic testGating();
    logic [7:0] v;
    busWrite(2'd0, 8'h08);
    check("R8 mute off", {7'b0, dacMute}, 8'h00);
    busWrite(2'd1, 8'h77);
    busRead(2'd1, v); check("R9 entry8 held", v, 8'h00);
    busWrite(2'd0, 8'h09);
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, v); check("R9 entry9 enables only", v, 8'h03);
    busWrite(2'd0, 8'h1C);
    busWrite(2'd1, 8'h11);
    busRead(2'd1, v); check("R9 entry28 held", v, 8'h00);
    busWrite(2'd0, 8'h48);
    check("R8 mute on", {7'b0, dacMute}, 8'h01);
    busWrite(2'd1, 8'h77);
    busRead(2'd1, v); check("R9 entry8 open", v, 8'h77);
  endtask

  task automatic testStatus();
    logic [7:0] v;
    pbReady = 1'b1; pbLeft = 1'b0;
    @(negedge clk); intSet = 1'b1;
    @(negedge clk); intSet = 1'b0;
    busRead(2'd2, v); check("R5 status", v, 8'h03);
    check("R7 irq gated off", {7'b0, irq}, 8'h00);
    busWrite(2'd0, 8'h4A);
    busWrite(2'd1, 8'h02);
    check("R7 irq on", {7'b0, irq}, 8'h01);
    pbLeft = 1'b1;
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, v); check("R6 cleared", v, 8'h06);
    check("R7 irq off after clear", {7'b0, irq}, 8'h00);
    @(negedge clk);
    addr = 2'd2; wrEn = 1'b1; intSet = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; intSet = 1'b0;
    busRead(2'd2, v); check("R6 set wins", v, 8'h07);
  endtask

  task automatic testPlayback();
    logic [7:0] v;
    busWrite(2'd3, 8'h9D);
    busRead(2'd3, v); check("R10 playback byte", v, 8'h9D);
    @(negedge clk); addr = 2'd3; rdEn = 1'b0;
    #1 check("R11 idle read zero", rdData, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testInit();
    testMode1();
    testMode2();
    testGating();
    testStatus();
    testPlayback();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule